// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens to the data and clock lines of an I2C bus and recognises the two framing events. A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. It keeps two status flags: one for the last START and one for the last STOP. Only the flag for the most recent event is set, and a bus-free output is derived from the pair. Firmware that runs a bus master in software reads the bus-free output before it drives the lines.

The block also holds a sticky interrupt-pending flag. The flag is set by a START, by a STOP, or by a one-cycle byte-done strobe from the neighbouring shift logic. It stays set until a clear strobe arrives. The interrupt output is the pending flag gated by an interrupt enable, so enabling the interrupt while the bus is busy means the next STOP signals that the bus has become free. Both bus lines pass through a synchroniser of `SYNC_STAGES` flops, which defaults to two, before edges are detected. When the module enable is low, both status flags are held clear and no event is recorded.

Top module: `i2c_cond_monitor`

## Requirements
- R1: After reset, `start_seen`, `stop_seen` and `irq_pend` are 0 and `bus_free` is 1.
- R2: While `mon_en` is 1, the data line falling with the clock line high sets `start_seen` to 1 and clears `stop_seen` in the same cycle. With the default two synchroniser stages, this takes effect on the third rising clock edge after the line change.
- R3: While `mon_en` is 1, the data line rising with the clock line high sets `stop_seen` to 1 and clears `start_seen` in the same cycle, with the same latency as R2. The two flags are never both 1.
- R4: `bus_free` is 1 when `stop_seen` is 1 or when both flags are 0, and 0 otherwise.
- R5: Data line changes while the clock line is low do not change either flag. Clock line changes never change either flag.
- R6: A START, a STOP, or `byte_done` high for one cycle while `mon_en` is 1 sets `irq_pend`. `irq_pend` then stays 1 until cleared.
- R7: `irq_clr` high clears `irq_pend` on the next edge. If a setting event occurs in the same cycle as `irq_clr`, the setting event wins and `irq_pend` stays 1.
- R8: `irq_out` equals `irq_pend` AND `irq_en`. If the interrupt is enabled while the bus is busy with no pending flag, the next STOP drives `irq_out` to 1.
- R9: While `mon_en` is 0, both flags are cleared, and bus events and `byte_done` do not set `irq_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_en | input | 1 | Module enable |
| sda_in | input | 1 | Data line level |
| scl_in | input | 1 | Clock line level |
| byte_done | input | 1 | One-cycle strobe when a byte has been sent or received |
| irq_clr | input | 1 | One-cycle strobe that clears the pending flag |
| irq_en | input | 1 | Interrupt enable |
| start_seen | output | 1 | Set when the last bus event was a START |
| stop_seen | output | 1 | Set when the last bus event was a STOP |
| bus_free | output | 1 | The bus may be taken by a master |
| irq_pend | output | 1 | Sticky interrupt-pending flag |
| irq_out | output | 1 | Gated interrupt request |

## Verification
The bench toggles one bus line at a time. This shows whether a design confuses a data change during the clock-low phase with a framing event; such a design would set a flag in the middle of a byte. It pulses the byte-done strobe and the clear strobe in the same cycle, where a design that gives the clear priority would lose an interrupt. It drops the module enable between events, where a design that gates only detection would leave stale flags set. One directed sequence turns the interrupt on while the bus is busy and expects the STOP to raise the request. A design that wrongly gated the pending flag itself with the enable would fail that sequence.

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic sda_in,
  input  logic scl_in,
  input  logic byte_done,
  input  logic irq_clr,
  input  logic irq_en,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free,
  output logic irq_pend,
  output logic irq_out
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sda_sync, scl_sync;
  logic sda_d, scl_d;
  logic sda_s, scl_s;
  logic start_det, stop_det, set_irq;

  // Idle bus reads high, so synchroniser flops reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sync <= '1;
      scl_sync <= '1;
      sda_d    <= 1'b1;
      scl_d    <= 1'b1;
    end else begin
      sda_sync <= {sda_sync[LAST-1:0], sda_in};
      scl_sync <= {scl_sync[LAST-1:0], scl_in};
      sda_d    <= sda_s;
      scl_d    <= scl_s;
    end
  end

  assign sda_s = sda_sync[LAST];
  assign scl_s = scl_sync[LAST];

  assign start_det = scl_s && scl_d && sda_d && !sda_s;
  assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
  assign set_irq   = mon_en && (start_det || stop_det || byte_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else if (!mon_en) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else if (start_det) begin
      start_seen <= 1'b1;
      stop_seen  <= 1'b0;
    end else if (stop_det) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_pend <= 1'b0;
    else if (set_irq)  irq_pend <= 1'b1;
    else if (irq_clr)  irq_pend <= 1'b0;
  end

  assign bus_free = stop_seen || !start_seen;
  assign irq_out  = irq_pend && irq_en;

  assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && start_det) |=> (start_seen && !stop_seen));

  assert_stop_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && stop_det) |=> (stop_seen && !start_seen));

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));

  assert_scl_low_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && !scl_s) |=> ($stable(start_seen) && $stable(stop_seen)));

  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_clr) |=> irq_pend);

  assert_byte_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && byte_done) |=> irq_pend);

  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !set_irq) |=> !irq_pend);

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> (!start_seen && !stop_seen));

  assert_disable_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !irq_pend) |=> !irq_pend);

endmodule

// File: tb/tb_i2c_cond_monitor.sv
module tb_i2c_cond_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 1500;

  logic clk = 0, rst_n = 0;
  logic mon_en = 0, sda_in = 1, scl_in = 1, byte_done = 0, irq_clr = 0, irq_en = 0;
  logic start_seen, stop_seen, bus_free, irq_pend, irq_out;

  int vectors = 0, miscompares = 0;
  logic m_s = 0, m_p = 0, m_irq = 0;

  i2c_cond_monitor dut (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .sda_in(sda_in), .scl_in(scl_in),
    .byte_done(byte_done), .irq_clr(irq_clr), .irq_en(irq_en),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
    .irq_pend(irq_pend), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic free_of(logic s, logic p);
    return p | (!s & !p);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag_sp, string tag_irq);
    chk(tag_sp, "start_seen", start_seen, m_s);
    chk(tag_sp, "stop_seen", stop_seen, m_p);
    chk("R4", "bus_free", bus_free, free_of(m_s, m_p));
    chk(tag_irq, "irq_pend", irq_pend, m_irq);
    chk("R8", "irq_out", irq_out, m_irq & irq_en);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic toggle_sda();
    string tag;
    if (!mon_en) tag = "R9";
    else if (!scl_in) tag = "R5";
    else if (sda_in) begin
      tag = "R2"; m_s = 1; m_p = 0; m_irq = 1;
    end else begin
      tag = "R3"; m_s = 0; m_p = 1; m_irq = 1;
    end
    sda_in = !sda_in;
    settle();
    check_all(tag, "R6");
  endtask

  task automatic toggle_scl();
    scl_in = !scl_in;
    settle();
    check_all("R5", "R6");
  endtask

  task automatic pulse(logic bd, logic cl);
    byte_done = bd; irq_clr = cl;
    @(negedge clk);
    byte_done = 0; irq_clr = 0;
    if (bd && mon_en) m_irq = 1;
    else if (cl) m_irq = 0;
    settle();
    check_all("R6", (bd && cl) ? "R7" : (cl ? "R7" : (mon_en ? "R6" : "R9")));
  endtask

  task automatic set_en(logic v);
    mon_en = v;
    if (!v) begin m_s = 0; m_p = 0; end
    settle();
    check_all("R9", "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_all("R1", "R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1", "R1");

    set_en(1);
    // Directed: START then STOP with the clock high.
    toggle_sda();
    toggle_sda();
    // Data changes during clock low are ignored.
    toggle_scl();
    toggle_sda();
    toggle_sda();
    toggle_scl();
    // Set and clear in the same cycle: set wins.
    pulse(0, 1);
    pulse(1, 1);
    pulse(0, 1);
    // Directed: interrupt enabled while busy, then STOP.
    irq_en = 0;
    toggle_sda();
    pulse(0, 1);
    irq_en = 1;
    @(negedge clk);
    check_all("R8", "R8");
    toggle_sda();
    chk("R8", "irq_out after stop", irq_out, 1'b1);
    pulse(0, 1);
    // Disabled: events ignored, flags cleared.
    toggle_sda();
    set_en(0);
    toggle_sda();
    toggle_sda();
    pulse(1, 0);
    set_en(1);

    for (int i = 0; i < STEPS; i++) begin
      int unsigned r = $urandom % 16;
      if (r < 6) toggle_sda();
      else if (r < 9) toggle_scl();
      else if (r < 11) pulse(1, 0);
      else if (r < 12) pulse(0, 1);
      else if (r < 13) pulse(1, 1);
      else if (r < 14) set_en(!mon_en);
      else begin
        irq_en = !irq_en;
        @(negedge clk);
        check_all("R8", "R8");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule